// File: doc/BRIEF.md
# Multi-mode shift register with carry rotate

This block is a 16-bit data register that updates once per clock according to a set of plain control lines. In any cycle it can take a new value from a parallel input bus, rotate right by one place through an externally supplied carry bit, shift right by one place while keeping the sign, shift right by one place with a zero entering at the top, or shift left by one place with a zero entering at the bottom. When no control line is raised, the register holds its contents.

The control lines are meant to be one-hot. If several are raised together, a fixed priority picks one operation: load first, then rotate, then arithmetic right shift, then logical right shift, then left shift. A combinational shift-out pin gives the bit that leaves the register at the coming edge, so a neighbouring flag unit can capture it. Where the carry comes from and how flags are formed lie outside this block.

Every pin is a plain control or data line sampled at each rising clock edge. There is no valid/ready handshake: the register never stalls and applies back-pressure to nothing.

Top module: `shreg_multi`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises with no control line raised, `q` is 0x0000.
- R2: With none of `ctl_load`, `ctl_rotr`, `ctl_sra`, `ctl_srl` and `ctl_shl` raised, `q` keeps its value at the next edge.
- R3: With `ctl_load` raised, `q` takes `din` at the next edge.
- R4: With `ctl_sra` as the selected operation, the next `q` is the current `q` moved one place towards bit 0, with bit 15 keeping its old value.
- R5: With `ctl_srl` as the selected operation, the next `q` is the current `q` moved one place towards bit 0, with a 0 in bit 15.
- R6: With `ctl_shl` as the selected operation, the next `q` is the current `q` moved one place towards bit 15, with a 0 in bit 0.
- R7: With `ctl_rotr` as the selected operation, the next `q` is the current `q` moved one place towards bit 0, with `carry_in` in bit 15.
- R8: When more than one control line is raised, the operation applied is the first raised one in the order load, rotate, arithmetic right, logical right, left.
- R9: `shift_out` equals `q[0]` when the selected operation is rotate or either right shift, equals `q[15]` when it is the left shift, and is 0 for load or hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_load | input | 1 | Parallel load from `din` |
| ctl_rotr | input | 1 | Rotate right through `carry_in` |
| ctl_sra | input | 1 | Sign-preserving right shift |
| ctl_srl | input | 1 | Zero-fill right shift |
| ctl_shl | input | 1 | Zero-fill left shift |
| carry_in | input | 1 | Bit entering the top on a rotate |
| din | input | 16 | Parallel load data |
| q | output | 16 | Register contents |
| shift_out | output | 1 | Bit leaving the register at the next edge |

## Verification
The assertions check on every cycle that hold keeps the value, that load takes the bus, that each right move and the left shift place the neighbouring bits and the correct fill bit, and that the rotate brings the carry into the top. The priority among simultaneous control lines, the shift-out pin for every mode and the reset value are shown only by the bench, whose reference model predicts `q` and `shift_out` each cycle across directed sequences, all pairs of conflicting controls and a long stretch of random control and data.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [2:0] {
    MODE_HOLD = 3'd0,
    MODE_LOAD = 3'd1,
    MODE_ROTR = 3'd2,
    MODE_SRA  = 3'd3,
    MODE_SRL  = 3'd4,
    MODE_SHL  = 3'd5
  } mode_e;
endpackage

// File: rtl/shreg_mode_sel.sv
module shreg_mode_sel
  import shreg_pkg::*;
(
  input  logic  ctl_load,
  input  logic  ctl_rotr,
  input  logic  ctl_sra,
  input  logic  ctl_srl,
  input  logic  ctl_shl,
  output mode_e mode
);
  // Fixed priority: load, rotate, arithmetic right, logical right, left (R8)
  always_comb begin
    if (ctl_load)      mode = MODE_LOAD;
    else if (ctl_rotr) mode = MODE_ROTR;
    else if (ctl_sra)  mode = MODE_SRA;
    else if (ctl_srl)  mode = MODE_SRL;
    else if (ctl_shl)  mode = MODE_SHL;
    else               mode = MODE_HOLD;
  end
endmodule

// File: rtl/shreg_bit_next.sv
module shreg_bit_next
  import shreg_pkg::*;
(
  input  mode_e mode,
  input  logic  own,
  input  logic  from_above,
  input  logic  from_below,
  input  logic  load_bit,
  output logic  next
);
  always_comb begin
    unique case (mode)
      MODE_LOAD: next = load_bit;
      MODE_ROTR,
      MODE_SRA,
      MODE_SRL:  next = from_above;
      MODE_SHL:  next = from_below;
      default:   next = own;
    endcase
  end
endmodule

// File: rtl/shreg_multi.sv
module shreg_multi
  import shreg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_load,
  input  logic         ctl_rotr,
  input  logic         ctl_sra,
  input  logic         ctl_srl,
  input  logic         ctl_shl,
  input  logic         carry_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         shift_out
);
  localparam int MSB = W - 1;

  mode_e          mode;
  logic           top_fill;
  logic [W-1:0]   q_next;

  shreg_mode_sel u_sel (
    .ctl_load (ctl_load),
    .ctl_rotr (ctl_rotr),
    .ctl_sra  (ctl_sra),
    .ctl_srl  (ctl_srl),
    .ctl_shl  (ctl_shl),
    .mode     (mode)
  );

  // Bit entering the top on a right move
  always_comb begin
    unique case (mode)
      MODE_ROTR: top_fill = carry_in;
      MODE_SRA:  top_fill = q[MSB];
      default:   top_fill = 1'b0;
    endcase
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic above;
      logic below;
      if (i == MSB) begin : g_top
        assign above = top_fill;
      end else begin : g_mid_hi
        assign above = q[i+1];
      end
      if (i == 0) begin : g_bot
        assign below = 1'b0;
      end else begin : g_mid_lo
        assign below = q[i-1];
      end
      shreg_bit_next u_bit (
        .mode       (mode),
        .own        (q[i]),
        .from_above (above),
        .from_below (below),
        .load_bit   (din[i]),
        .next       (q_next[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  always_comb begin
    unique case (mode)
      MODE_ROTR, MODE_SRA, MODE_SRL: shift_out = q[0];
      MODE_SHL:                      shift_out = q[MSB];
      default:                       shift_out = 1'b0;
    endcase
  end

  // ---- assertions ----
  logic none_raised;
  assign none_raised = !(ctl_load || ctl_rotr || ctl_sra || ctl_srl || ctl_shl);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    none_raised |=> $stable(q));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> q == $past(din));

  assert_sra_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sra && !ctl_load && !ctl_rotr) |=>
      (q[MSB] == $past(q[MSB])) && (q[MSB-1:0] == $past(q[MSB:1])));

  assert_srl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_srl && !ctl_load && !ctl_rotr && !ctl_sra) |=>
      (q[MSB] == 1'b0) && (q[MSB-1:0] == $past(q[MSB:1])));

  assert_shl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_shl && none_raised == 1'b0 && !ctl_load && !ctl_rotr && !ctl_sra && !ctl_srl) |=>
      (q[0] == 1'b0) && (q[MSB:1] == $past(q[MSB-1:0])));

  assert_rotr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rotr && !ctl_load) |=>
      (q[MSB] == $past(carry_in)) && (q[MSB-1:0] == $past(q[MSB:1])));
endmodule

// File: tb/tb_shreg_multi.sv
module tb_shreg_multi;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_load = 0, ctl_rotr = 0, ctl_sra = 0, ctl_srl = 0, ctl_shl = 0;
  logic        carry_in = 0;
  logic [15:0] din = '0;
  logic [15:0] q;
  logic        shift_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] model_q = '0;

  always #2.5 clk = ~clk;

  shreg_multi dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_load(ctl_load), .ctl_rotr(ctl_rotr), .ctl_sra(ctl_sra),
    .ctl_srl(ctl_srl), .ctl_shl(ctl_shl),
    .carry_in(carry_in), .din(din), .q(q), .shift_out(shift_out)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: ld, rotr, sra, srl, shl packed as 5 bits (MSB = load)
  task automatic step(logic [4:0] c, logic cy, logic [15:0] d);
    logic [15:0] nq;
    logic        so;
    string       tag;
    int          n;
    @(negedge clk);
    {ctl_load, ctl_rotr, ctl_sra, ctl_srl, ctl_shl} = c;
    carry_in = cy;
    din = d;
    n = $countones(c);
    if (c[4])      begin nq = d;                                so = 1'b0;        tag = "R3"; end
    else if (c[3]) begin nq = {cy, model_q[15:1]};              so = model_q[0];  tag = "R7"; end
    else if (c[2]) begin nq = {model_q[15], model_q[15:1]};     so = model_q[0];  tag = "R4"; end
    else if (c[1]) begin nq = {1'b0, model_q[15:1]};            so = model_q[0];  tag = "R5"; end
    else if (c[0]) begin nq = {model_q[14:0], 1'b0};            so = model_q[15]; tag = "R6"; end
    else           begin nq = model_q;                          so = 1'b0;        tag = "R2"; end
    if (n > 1) tag = "R8";
    #1;
    check("R9 shift_out", {15'd0, shift_out}, {15'd0, so});
    @(posedge clk);
    #1;
    model_q = nq;
    check(tag, q, model_q);
  endtask

  initial begin
    #1;
    check("R1 in reset", q, 16'h0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(5'b00000, 1'b0, 16'hFFFF);      // R1 value held after reset
    check("R1 after reset", q, 16'h0000);
    step(5'b10000, 1'b0, 16'h8001);      // R3
    step(5'b00100, 1'b0, 16'h0000);      // R4 sign kept
    step(5'b00100, 1'b0, 16'h0000);
    step(5'b00010, 1'b0, 16'h0000);      // R5
    step(5'b00001, 1'b0, 16'h0000);      // R6
    step(5'b00001, 1'b0, 16'h0000);
    step(5'b10000, 1'b0, 16'h4003);
    step(5'b01000, 1'b1, 16'h0000);      // R7 carry in 1
    step(5'b01000, 1'b0, 16'h0000);      // R7 carry in 0
    step(5'b00000, 1'b1, 16'h1234);      // R2
    step(5'b00000, 1'b0, 16'hABCD);
    step(5'b10000, 1'b0, 16'h7FFE);
    step(5'b00100, 1'b1, 16'h0000);      // R4 positive
    step(5'b10001, 1'b1, 16'hC3C3);      // R8 load beats shl
    step(5'b01100, 1'b0, 16'h0000);      // R8 rotr beats sra
    step(5'b00110, 1'b0, 16'h0000);      // R8 sra beats srl
    step(5'b00011, 1'b0, 16'h0000);      // R8 srl beats shl
    step(5'b11111, 1'b1, 16'h5A5A);      // R8 all raised
    step(5'b01111, 1'b1, 16'h0000);
    for (int k = 0; k < 400; k++) begin
      logic [4:0] c;
      c = 5'($urandom);
      if (k % 3 != 0) c = 5'(1 << ($urandom % 6));
      step(c, 1'($urandom), 16'($urandom));
    end
    finish_run();
  end
endmodule